// File: doc/BRIEF.md
# Multi-mode 16-bit timer/counter

A single 16-bit counter with a byte-wide register port that runs in one of four modes:
- **Capture**: a falling edge on the trigger pin latches the count.
- **Auto-reload**: counts up, or counts up and down under control of the trigger pin.
- **Baud generator**: produces receive and transmit ticks for a serial port.
- **Clock output**: produces a 50% duty square wave.

The core supplies two strobes. `cyc_en` marks each machine cycle (twelve oscillator periods). `state_en` marks each state time (two oscillator periods). The block runs on the oscillator clock.

Two pins are sampled once per machine cycle. A falling edge is a high sample followed by a low sample. The count pin supplies events in counter function. The trigger pin causes captures, reloads and external flags, or sets the count direction in up/down mode. The overflow flag and the external flag stay set until software writes them. Either flag raises the interrupt request, with the exceptions given in the requirements.

Top module: `timer16_multimode`

## Requirements
- R1: After reset every register reads 0, and irq, rx_tick, tx_tick and clk_out are low. The register addresses are: 0 control, 1 mode, 2 reload low byte, 3 reload high byte, 4 count low byte, 5 count high byte. Control bits are: 7 overflow flag, 6 external flag, 5 receive-tick select, 4 transmit-tick select, 3 external enable, 2 run, 1 counter select, 0 capture select. Mode bits are: 1 clock-out enable, 0 down-count enable.
- R2: In timer function (counter select 0), with run set and the block in capture or reload mode, the count rises by one on each cycle where `cyc_en` is high, and on no other cycle.
- R3: In counter function (counter select 1), the count rises by one at a `cyc_en` sample where `cnt_pin` is low and the previous sample was high.
- R4: In capture mode (capture select 1, both tick selects 0, no clock-out), with external enable set, a trigger falling edge has three effects: the pre-edge count is copied into the reload register, the external flag is set, and counting continues.
- R5: In capture mode, a step from 0xFFFF gives 0x0000 and sets the overflow flag.
- R6: In reload mode with down-count disabled, a step from 0xFFFF loads the reload value and sets the overflow flag. With external enable set, a trigger falling edge loads the reload value and sets the external flag.
- R7: In reload mode with down-count enabled, the trigger pin sets the direction: 1 counts up, 0 counts down.
  - Counting down, a step while the count equals the reload value loads 0xFFFF and sets the overflow flag.
  - Every overflow or underflow inverts the external flag.
  - In this mode the external flag does not drive irq.
- R8: With either tick select set, the counter steps on `state_en` and reloads at rollover, and the overflow flag is not set. Every 16th rollover gives a one-cycle pulse on rx_tick and/or tx_tick, according to the selects.
- R9: In baud mode, a trigger falling edge with external enable set sets the external flag and does not reload the count.
- R10: With clock-out enabled and timer function selected, the counter steps on `state_en` and reloads at rollover without setting the overflow flag, and clk_out inverts at each rollover.
- R11: irq is high while either flag is set (subject to R7), and hardware never clears a flag. With run clear, the count does not advance.
- R12: When a software write to the control register and a hardware flag set fall in the same cycle, the hardware set wins. When a capture and a reload-register write fall in the same cycle, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_en | input | 1 | Machine-cycle strobe |
| state_en | input | 1 | State-time strobe |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | Trigger / direction input |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt request |
| rx_tick | output | 1 | Receive baud tick |
| tx_tick | output | 1 | Transmit baud tick |
| clk_out | output | 1 | Clock-out square wave |

## Verification
The assertions assume the following about the inputs:
- The strobes and both pins are synchronous to `clk`.
- The mode changes only through a control or mode write.
- Every property about the flags or the count excludes cycles in which software writes the register concerned.

The bench drives `cyc_en` and `state_en` from a phase counter as one-in-twelve and one-in-two strobes. It changes pins only between edges and writes only addresses 0 to 5. The random phase biases the reload and count high bytes toward 0xFF, so that rollovers, underflows and baud ticks occur often inside the window.

// File: rtl/timer16_multimode.sv
module timer16_multimode #(
  parameter int DIV_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_en,
  input  logic       state_en,
  input  logic       cnt_pin,
  input  logic       trig_pin,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       rx_tick,
  output logic       tx_tick,
  output logic       clk_out
);
  localparam int CW = 16;
  localparam logic [CW-1:0] TOP = '1;
  localparam logic [DIV_W-1:0] DIV_LAST = '1;

  logic [7:0]       ctrl, ctrl_nx;
  logic [1:0]       mode;
  logic [CW-1:0]    cnt, cnt_nx, rld, rld_nx;
  logic             cs, ts;
  logic [DIV_W-1:0] div;

  logic run, ctsel, cap, xen, baud, clko, free, updown, down;
  logic cfall, tfall, step, at_top, wrap_up, wrap_dn, ext_evt, ext_load, capture;
  logic ovf_set, ext_tog, roll, wr_ctrl;

  assign run     = ctrl[2];
  assign ctsel   = ctrl[1];
  assign cap     = ctrl[0];
  assign xen     = ctrl[3];
  assign baud    = ctrl[5] | ctrl[4];
  assign clko    = mode[1] & ~ctsel;
  assign free    = baud | clko;
  assign updown  = mode[0] & ~cap & ~free;
  assign down    = updown & ~trig_pin;

  assign cfall   = cyc_en & cs & ~cnt_pin;
  assign tfall   = cyc_en & ts & ~trig_pin;
  assign step    = run & (ctsel ? cfall : (free ? state_en : cyc_en));
  assign at_top  = (cnt == TOP);
  assign wrap_up = step & ~down & at_top;
  assign wrap_dn = step & down & (cnt == rld);
  assign ext_evt = tfall & xen & ~updown;
  assign ext_load = ext_evt & ~cap & ~free;
  assign capture = ext_evt & cap & ~free;
  assign ovf_set = (wrap_up | wrap_dn) & ~free;
  assign ext_tog = (wrap_up | wrap_dn) & updown;
  assign roll    = wrap_up & free;
  assign wr_ctrl = wr_en && addr == 3'd0;

  always_comb begin
    cnt_nx = cnt;
    if (ext_load) cnt_nx = rld;
    else if (wrap_dn) cnt_nx = TOP;
    else if (wrap_up && !(cap && !free)) cnt_nx = rld;
    else if (step) cnt_nx = down ? cnt - 1'b1 : cnt + 1'b1;
    if (wr_en && addr == 3'd4) cnt_nx[7:0] = wr_data;
    if (wr_en && addr == 3'd5) cnt_nx[15:8] = wr_data;
  end

  always_comb begin
    rld_nx = rld;
    if (wr_en && addr == 3'd2) rld_nx[7:0] = wr_data;
    if (wr_en && addr == 3'd3) rld_nx[15:8] = wr_data;
    if (capture) rld_nx = cnt;
  end

  always_comb begin
    ctrl_nx = wr_ctrl ? wr_data : ctrl;
    if (ovf_set) ctrl_nx[7] = 1'b1;
    if (ext_tog) ctrl_nx[6] = ~ctrl[6];
    if (ext_evt) ctrl_nx[6] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      mode    <= '0;
      cnt     <= '0;
      rld     <= '0;
      cs      <= 1'b0;
      ts      <= 1'b0;
      div     <= '0;
      rx_tick <= 1'b0;
      tx_tick <= 1'b0;
      clk_out <= 1'b0;
    end else begin
      ctrl <= ctrl_nx;
      cnt  <= cnt_nx;
      rld  <= rld_nx;
      if (wr_en && addr == 3'd1) mode <= wr_data[1:0];
      if (cyc_en) begin
        cs <= cnt_pin;
        ts <= trig_pin;
      end
      if (roll && baud) div <= div + 1'b1;
      rx_tick <= roll & baud & (div == DIV_LAST) & ctrl[5];
      tx_tick <= roll & baud & (div == DIV_LAST) & ctrl[4];
      if (roll && clko) clk_out <= ~clk_out;
    end
  end

  assign irq = ctrl[7] | (ctrl[6] & ~updown);

  always_comb begin
    case (addr)
      3'd0:    rd_data = ctrl;
      3'd1:    rd_data = {6'b0, mode};
      3'd2:    rd_data = rld[7:0];
      3'd3:    rd_data = rld[15:8];
      3'd4:    rd_data = cnt[7:0];
      3'd5:    rd_data = cnt[15:8];
      default: rd_data = 8'h00;
    endcase
  end

  p_run_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en && !xen) |=> cnt == $past(cnt));
  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[7] && !wr_ctrl) |=> ctrl[7]);
  p_no_ovf_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (free && !ctrl[7] && !wr_ctrl) |=> !ctrl[7]);
  p_hw_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ctrl[7]);
  p_clk_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clko |=> $stable(clk_out));
  p_rx_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tick |-> $past(ctrl[5]));
endmodule

// File: tb/timer16_multimode_test.sv
module timer16_multimode_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc_en = 0, state_en = 0, cnt_pin = 1, trig_pin = 1, wr_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic irq, rx_tick, tx_tick, clk_out;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  timer16_multimode uut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .state_en(state_en),
    .cnt_pin(cnt_pin), .trig_pin(trig_pin), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .rx_tick(rx_tick),
    .tx_tick(tx_tick), .clk_out(clk_out));

  logic [7:0] m_ctrl;
  logic [1:0] m_mode;
  logic [15:0] m_rld, m_cnt;
  logic m_cs, m_ts, m_clk, m_rx, m_tx;
  logic [3:0] m_div;

  task automatic m_reset();
    m_ctrl = 0; m_mode = 0; m_rld = 0; m_cnt = 0;
    m_cs = 0; m_ts = 0; m_clk = 0; m_rx = 0; m_tx = 0; m_div = 0;
  endtask

  function automatic logic m_updown();
    logic fr;
    fr = m_ctrl[5] | m_ctrl[4] | (m_mode[1] & ~m_ctrl[1]);
    return m_mode[0] & ~m_ctrl[0] & ~fr;
  endfunction

  task automatic model_step(input logic ce, se, cp, tp, w, input logic [2:0] a, input logic [7:0] d);
    logic bd, co, fr, ud, dn, ec, et, stp, evt, ovf, tog, roll;
    logic [7:0] nctrl;
    logic [15:0] ncnt, nrld;
    bd = m_ctrl[5] | m_ctrl[4];
    co = m_mode[1] & ~m_ctrl[1];
    fr = bd | co;
    ud = m_updown();
    dn = ud & ~tp;
    ec = ce & m_cs & ~cp;
    et = ce & m_ts & ~tp;
    if (!m_ctrl[2]) stp = 0;
    else if (m_ctrl[1]) stp = ec;
    else if (fr) stp = se;
    else stp = ce;
    evt = et & m_ctrl[3] & ~ud;
    ncnt = m_cnt; nrld = m_rld; ovf = 0; tog = 0; roll = 0;
    if (stp) begin
      if (dn) begin
        if (m_cnt == m_rld) begin ncnt = 16'hFFFF; ovf = 1; tog = 1; end
        else ncnt = m_cnt - 16'd1;
      end else if (m_cnt == 16'hFFFF) begin
        if (fr) begin ncnt = m_rld; roll = 1; end
        else begin ovf = 1; tog = ud; ncnt = m_ctrl[0] ? 16'h0000 : m_rld; end
      end else ncnt = m_cnt + 16'd1;
    end
    if (w && a == 3'd2) nrld[7:0] = d;
    if (w && a == 3'd3) nrld[15:8] = d;
    if (evt && !fr) begin
      if (m_ctrl[0]) nrld = m_cnt;
      else ncnt = m_rld;
    end
    if (w && a == 3'd4) ncnt[7:0] = d;
    if (w && a == 3'd5) ncnt[15:8] = d;
    nctrl = (w && a == 3'd0) ? d : m_ctrl;
    if (ovf) nctrl[7] = 1;
    if (tog) nctrl[6] = ~m_ctrl[6];
    if (evt) nctrl[6] = 1;
    m_rx = roll & bd & (m_div == 4'hF) & m_ctrl[5];
    m_tx = roll & bd & (m_div == 4'hF) & m_ctrl[4];
    if (roll && bd) m_div = m_div + 4'd1;
    if (roll && co) m_clk = ~m_clk;
    if (ce) begin m_cs = cp; m_ts = tp; end
    if (w && a == 3'd1) m_mode = d[1:0];
    m_ctrl = nctrl; m_cnt = ncnt; m_rld = nrld;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a; #1; v = rd_data;
  endtask

  task automatic cmp_model(input string req);
    logic [7:0] v;
    rd(0, v); chk(req, v, m_ctrl);
    rd(1, v); chk(req, v, {6'b0, m_mode});
    rd(2, v); chk(req, v, m_rld[7:0]);
    rd(3, v); chk(req, v, m_rld[15:8]);
    rd(4, v); chk(req, v, m_cnt[7:0]);
    rd(5, v); chk(req, v, m_cnt[15:8]);
    chk(req, irq, m_ctrl[7] | (m_ctrl[6] & ~m_updown()));
    chk(req, clk_out, m_clk);
    chk(req, rx_tick, m_rx);
    chk(req, tx_tick, m_tx);
  endtask

  task automatic step(input logic ce, se, cp, tp, w, input logic [2:0] a, input logic [7:0] d);
    cyc_en = ce; state_en = se; cnt_pin = cp; trig_pin = tp;
    wr_en = w; addr = a; wr_data = d;
    model_step(ce, se, cp, tp, w, a, d);
    @(posedge clk); #2;
    wr_en = 0; cyc_en = 0; state_en = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(0, 0, cnt_pin, trig_pin, 1, a, d);
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 3'd1, hi); v = {hi, lo};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [15:0] v16, keep;
    int nrx, ntx;
    void'($urandom(32'd7));
    m_reset();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    cmp_model("R1");
    chk("R1", irq, 0);
    rd(0, v); chk("R1", v, 8'h00);

    // R2 timer function and reload on overflow (R6)
    wr(2, 8'h34); wr(3, 8'h12); wr(4, 8'hFE); wr(5, 8'hFF); wr(0, 8'h04);
    step(0, 1, 1, 1, 0, 0, 0);
    rd16(4, v16); chk("R2", v16, 16'hFFFE);
    step(1, 0, 1, 1, 0, 0, 0);
    rd16(4, v16); chk("R2", v16, 16'hFFFF);
    step(1, 0, 1, 1, 0, 0, 0);
    rd16(4, v16); chk("R6", v16, 16'h1234);
    rd(0, v); chk("R6", v, 8'h84);
    chk("R11", irq, 1);
    cmp_model("R2");

    // R12 write collides with overflow set
    wr(4, 8'hFF); wr(5, 8'hFF); wr(0, 8'h04);
    step(1, 0, 1, 1, 1, 0, 8'h04);
    rd(0, v); chk("R12", v, 8'h84);

    // R11 run clear holds count
    wr(0, 8'h00); wr(4, 8'h10); wr(5, 8'h00);
    repeat (5) step(1, 1, 1, 1, 0, 0, 0);
    rd16(4, v16); chk("R11", v16, 16'h0010);

    // R3 counter function
    wr(0, 8'h06);
    step(1, 0, 1, 1, 0, 0, 0);
    step(1, 0, 0, 1, 0, 0, 0);
    step(1, 0, 0, 1, 0, 0, 0);
    step(0, 0, 1, 1, 0, 0, 0);
    step(1, 0, 1, 1, 0, 0, 0);
    step(1, 0, 0, 1, 0, 0, 0);
    rd16(4, v16); chk("R3", v16, 16'h0012);
    cmp_model("R3");

    // R4 capture, R5 capture overflow
    wr(0, 8'h00); wr(4, 8'h00); wr(5, 8'h01); wr(0, 8'h0D);
    step(1, 0, 1, 1, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0, 0);
    rd16(2, v16); chk("R4", v16, 16'h0101);
    rd16(4, v16); chk("R4", v16, 16'h0102);
    rd(0, v); chk("R4", v, 8'h4D);
    wr(0, 8'h0D); wr(4, 8'hFF); wr(5, 8'hFF);
    step(1, 0, 1, 0, 0, 0, 0);
    rd16(4, v16); chk("R5", v16, 16'h0000);
    rd(0, v); chk("R5", v, 8'h8D);
    cmp_model("R5");

    // R6 trigger-forced reload
    wr(0, 8'h0C); wr(2, 8'h00); wr(3, 8'h50); wr(4, 8'h00); wr(5, 8'h00);
    step(1, 0, 1, 1, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0, 0);
    rd16(4, v16); chk("R6", v16, 16'h5000);
    rd(0, v); chk("R6", v, 8'h4C);

    // R7 up/down
    wr(0, 8'h00); wr(1, 8'h01); wr(2, 8'h10); wr(3, 8'h00);
    wr(4, 8'h11); wr(5, 8'h00); wr(0, 8'h04);
    step(1, 0, 1, 0, 0, 0, 0);
    rd16(4, v16); chk("R7", v16, 16'h0010);
    step(1, 0, 1, 0, 0, 0, 0);
    rd16(4, v16); chk("R7", v16, 16'hFFFF);
    rd(0, v); chk("R7", v, 8'hC4);
    wr(0, 8'h44);
    chk("R7", irq, 0);
    step(1, 0, 1, 1, 0, 0, 0);
    rd16(4, v16); chk("R7", v16, 16'h0010);
    rd(0, v); chk("R7", v, 8'h84);
    cmp_model("R7");

    // R8 baud ticks
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'hFE); wr(3, 8'hFF);
    wr(4, 8'hFE); wr(5, 8'hFF); wr(0, 8'h34);
    nrx = 0; ntx = 0;
    for (int k = 0; k < 192; k++) begin
      step(0, (k % 2) == 0, 1, 1, 0, 0, 0);
      nrx += int'(rx_tick); ntx += int'(tx_tick);
    end
    chk("R8", nrx, 3);
    chk("R8", ntx, 3);
    rd(0, v); chk("R8", v, 8'h34);
    cmp_model("R8");

    // R9 trigger edge in baud mode
    wr(0, 8'h3C);
    rd16(4, keep);
    step(1, 0, 1, 1, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0, 0);
    rd16(4, v16); chk("R9", v16, keep);
    rd(0, v); chk("R9", v, 8'h7C);

    // R10 clock out
    wr(0, 8'h00); wr(1, 8'h02); wr(2, 8'hFC); wr(3, 8'hFF);
    wr(4, 8'hFC); wr(5, 8'hFF); wr(0, 8'h04);
    repeat (4) step(0, 1, 1, 1, 0, 0, 0);
    chk("R10", clk_out, 1);
    rd(0, v); chk("R10", v, 8'h04);
    repeat (4) step(0, 1, 1, 1, 0, 0, 0);
    chk("R10", clk_out, 0);
    cmp_model("R10");

    // random phase against model
    begin
      int ph = 0;
      logic cp = 1, tp = 1;
      for (int i = 0; i < 5000; i++) begin
        logic w;
        logic [2:0] a;
        logic [7:0] d;
        if ($urandom % 10 == 0) cp = ~cp;
        if ($urandom % 14 == 0) tp = ~tp;
        w = ($urandom % 12) == 0;
        a = 3'($urandom % 6);
        d = 8'($urandom);
        if ((a == 3'd3 || a == 3'd5) && ($urandom % 2)) d = 8'hFF;
        if (a == 3'd0 && ($urandom % 2)) d[2] = 1'b1;
        step(ph % 12 == 0, ph % 2 == 0, cp, tp, w, a, d);
        ph++;
        cmp_model("R11");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule